// File: doc/BRIEF.md
# Byte-Serial Card Data FIFO Engine

This block sits between a host that moves 32-bit words and a card data path that moves one byte at a time. A 16-word FIFO buffers the data. On receive, card bytes are packed into words with the first byte in bits 7:0. On transmit, each word is split into bytes and the lowest byte goes out first. A programmed byte count decides how many bytes move. When that count runs out in the middle of a word, the partial word is handled correctly in both directions.

The host starts a transfer with a one-cycle `xfer_start` pulse, which carries the direction and a 16-bit length. The start pulse loads the remaining byte count and flushes both the FIFO and the byte packers. A small state machine then runs the transfer:

| State | Meaning |
|---|---|
| IDLE | No transfer is in progress. |
| MOVE | Bytes are being transferred. |
| DRAIN | The byte count is zero, but words are still left in the FIFO. |

The transitions are:

- **Launch:** IDLE, MOVE or DRAIN goes to MOVE on a start pulse with a nonzero length.
- **Null start:** a start pulse with zero length goes straight to IDLE.
- **Count out:** MOVE goes to DRAIN when the last byte moves.
- **Settle:** DRAIN goes to IDLE when the FIFO level is zero.

The block reports FIFO status flags only for the direction in use. It also gives the remaining byte count, a word-count readback, and two end-of-transfer indications.

Top module: `card_byte_fifo_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits, and its pointers wrap modulo 16. A push to a full FIFO is ignored. A pop from an empty FIFO is ignored, and `pop_data` reads zero whenever the FIFO is empty.
- R2: On receive, card bytes fill a word starting at bits 7:0 and moving up through the higher bytes. A word enters the FIFO after every fourth byte.
- R3: On receive, if the count reaches zero in the middle of a word, the partial word is pushed with its unfilled upper bytes set to zero.
- R4: On transmit, each word taken from the FIFO is sent lowest byte first, one byte per handshake, until the byte count is zero.
- R5: A start pulse loads `byte_count` from `xfer_len` at the next edge. Each byte moved decrements the count by one, and at most one byte moves per clock. A zero length returns the block to IDLE at once.
- R6: `data_end` and `block_end` are set together at the edge where the count reaches zero. A zero-length start sets them as well. A start with a nonzero length clears them.
- R7: Once the count is zero and the FIFO is empty, `busy` drops at the following edge and every flag of both groups reads 0.
- R8: Flag bits are encoded as follows, and hold only while busy:
  - bit0: active.
  - bit1: level is 0.
  - bit2: level is nonzero.
  - bit3: level is 16.
  - bit4: level is 8 or less for transmit, or 8 or more for receive.
- R9: `tx_flags` is driven only when the direction is 0 (transmit). `rx_flags` is driven only when the direction is 1 (receive). The other group reads 0.
- R10: `word_count` always equals (`byte_count` + 3) >> 2.
- R11: Receive accepts a byte only when `rx_byte_valid` is high, and holds `rx_byte_ready` low while the FIFO is full. Transmit moves a byte only when `tx_byte_ready` is high.
- R12: A host push is taken only in MOVE during transmit. A host pop is taken during receive, or in DRAIN during transmit. At all other times the push or pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle pulse that starts a transfer |
| xfer_dir | input | 1 | Direction sampled at start: 0 = transmit, 1 = receive |
| xfer_len | input | 16 | Byte count sampled at start |
| push_valid | input | 1 | Host word push request |
| push_data | input | 32 | Host word to push |
| pop_req | input | 1 | Host word pop request |
| pop_data | output | 32 | FIFO head word; reads zero when the FIFO is empty |
| rx_byte_valid | input | 1 | Card offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_ready | output | 1 | Engine accepts a received byte |
| tx_byte_valid | output | 1 | Engine offers a byte to send |
| tx_byte | output | 8 | Byte to send |
| tx_byte_ready | input | 1 | Card accepts the byte |
| busy | output | 1 | Transfer engine is enabled |
| byte_count | output | 16 | Remaining byte count |
| word_count | output | 15 | Remaining count in words, rounded up |
| data_end | output | 1 | Transfer end indication |
| block_end | output | 1 | Block end indication |
| tx_flags | output | 5 | Transmit FIFO flags (R8 encoding) |
| rx_flags | output | 5 | Receive FIFO flags (R8 encoding) |

## Verification
The properties assume that `xfer_start` is a single-cycle pulse. They also assume that the card side never changes a byte it is offering in the middle of a handshake.

The directed stimulus drives every input at the falling edge and holds it for a whole cycle. It raises `rx_byte_valid` only while a receive transfer is running, and raises `tx_byte_ready` only while the bench is collecting bytes. Host pushes and pops are issued one word per cycle, and each is removed before the next edge. Outputs are sampled at the falling edge after the rising edge that changed them.

// File: rtl/cbfe_pkg.sv
package cbfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MOVE  = 2'd1,
        ST_DRAIN = 2'd2
    } cbfe_state_e;

    localparam int FLG_W      = 5;
    localparam int FLG_ACTIVE = 0;
    localparam int FLG_EMPTY  = 1;
    localparam int FLG_AVAIL  = 2;
    localparam int FLG_FULL   = 3;
    localparam int FLG_HALF   = 4;

endpackage

// File: rtl/cbfe_word_fifo.sv
module cbfe_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             wr_ok;
    logic             rd_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign wr_ok   = wr_en && !full && !flush;
    assign rd_ok   = rd_en && !empty && !flush;
    assign rd_data = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (rd_ok) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/cbfe_rx_packer.sv
module cbfe_rx_packer #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int BPW = WORD_W / BYTE_W,
    localparam int IW  = $clog2(BPW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              last,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_push,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] acc;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] merged;

    always_comb begin
        merged    = acc | (WORD_W'(byte_in) << (idx * BYTE_W));
        word_out  = merged;
        word_push = take && ((idx == IW'(BPW - 1)) || last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clear) begin
            acc <= '0;
            idx <= '0;
        end else if (take) begin
            if (word_push) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= merged;
                idx <= idx + IW'(1);
            end
        end
    end

endmodule

// File: rtl/cbfe_tx_unpacker.sv
module cbfe_tx_unpacker #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int BPW = WORD_W / BYTE_W,
    localparam int CW  = $clog2(BPW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] head,
    input  logic              byte_ready,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out,
    output logic              fifo_pop,
    output logic              moved
);

    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     left;

    always_comb begin
        byte_valid = enable && ((left != '0) || !fifo_empty);
        byte_out   = (left != '0) ? shreg[BYTE_W-1:0] : head[BYTE_W-1:0];
        moved      = byte_valid && byte_ready;
        fifo_pop   = moved && (left == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (clear) begin
            shreg <= '0;
            left  <= '0;
        end else if (moved) begin
            if (left == '0) begin
                shreg <= head >> BYTE_W;
                left  <= CW'(BPW - 1);
            end else begin
                shreg <= shreg >> BYTE_W;
                left  <= left - CW'(1);
            end
        end
    end

endmodule

// File: rtl/cbfe_ctrl.sv
module cbfe_ctrl
    import cbfe_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             byte_moved,
    input  logic [LVL_W-1:0] level,
    output cbfe_state_e      state,
    output logic             dir_q,
    output logic [LEN_W-1:0] count,
    output logic             end_flag,
    output logic             busy,
    output logic             last_byte,
    output logic             rx_accept,
    output logic             tx_enable,
    output logic             host_push_ok,
    output logic             host_pop_ok,
    output logic [FLG_W-1:0] tx_flags,
    output logic [FLG_W-1:0] rx_flags
);

    cbfe_state_e      state_nx;
    logic             fifo_full;
    logic [FLG_W-1:0] base_tx;
    logic [FLG_W-1:0] base_rx;

    assign fifo_full = (level == LVL_W'(DEPTH));
    assign last_byte = (count == LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = (len_in != '0) ? ST_MOVE : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_MOVE:  if (byte_moved && last_byte) state_nx = ST_DRAIN;
                ST_DRAIN: if (level == '0) state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            count    <= '0;
            end_flag <= 1'b0;
        end else if (start) begin
            dir_q    <= dir_in;
            count    <= len_in;
            end_flag <= (len_in == '0);
        end else if (byte_moved) begin
            count <= count - LEN_W'(1);
            if (last_byte) begin
                end_flag <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b0;
        rx_accept    = 1'b0;
        tx_enable    = 1'b0;
        host_push_ok = 1'b0;
        host_pop_ok  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_MOVE: begin
                busy         = 1'b1;
                rx_accept    = dir_q && !fifo_full;
                tx_enable    = !dir_q;
                host_push_ok = !dir_q;
                host_pop_ok  = dir_q;
            end
            ST_DRAIN: begin
                busy        = 1'b1;
                host_pop_ok = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase

        base_tx             = '0;
        base_tx[FLG_ACTIVE] = 1'b1;
        base_tx[FLG_EMPTY]  = (level == '0);
        base_tx[FLG_AVAIL]  = (level != '0);
        base_tx[FLG_FULL]   = fifo_full;
        base_tx[FLG_HALF]   = (level <= LVL_W'(HALF));
        base_rx             = base_tx;
        base_rx[FLG_HALF]   = (level >= LVL_W'(HALF));

        tx_flags = (busy && !dir_q) ? base_tx : '0;
        rx_flags = (busy &&  dir_q) ? base_rx : '0;
    end

endmodule

// File: rtl/card_byte_fifo_engine.sv
module card_byte_fifo_engine
    import cbfe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 16,
    localparam int BPW   = WORD_W / BYTE_W,
    localparam int IW    = $clog2(BPW),
    localparam int LVL_W = $clog2(DEPTH) + 1,
    localparam int WC_W  = LEN_W + 1 - IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_dir,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              push_valid,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop_req,
    output logic [WORD_W-1:0] pop_data,
    input  logic              rx_byte_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_byte_ready,
    output logic              tx_byte_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_byte_ready,
    output logic              busy,
    output logic [LEN_W-1:0]  byte_count,
    output logic [WC_W-1:0]   word_count,
    output logic              data_end,
    output logic              block_end,
    output logic [FLG_W-1:0]  tx_flags,
    output logic [FLG_W-1:0]  rx_flags
);

    cbfe_state_e       state;
    logic              dir_q;
    logic              end_flag;
    logic              last_byte;
    logic              rx_accept;
    logic              tx_enable;
    logic              host_push_ok;
    logic              host_pop_ok;
    logic              rx_take;
    logic              tx_moved;
    logic              byte_moved;
    logic              pack_push;
    logic [WORD_W-1:0] pack_word;
    logic              unpack_pop;
    logic              fifo_wr;
    logic [WORD_W-1:0] fifo_wdata;
    logic              fifo_rd;
    logic [WORD_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              fifo_empty;
    logic [LEN_W:0]    cnt_round;

    assign rx_byte_ready = rx_accept;
    assign rx_take       = rx_byte_valid && rx_accept;
    assign byte_moved    = rx_take || tx_moved;
    assign fifo_wr       = pack_push || (push_valid && host_push_ok);
    assign fifo_wdata    = pack_push ? pack_word : push_data;
    assign fifo_rd       = unpack_pop || (pop_req && host_pop_ok);
    assign pop_data      = fifo_head;
    assign data_end      = end_flag;
    assign block_end     = end_flag;
    assign cnt_round     = {1'b0, byte_count} + (LEN_W+1)'(BPW - 1);
    assign word_count    = cnt_round[LEN_W:IW];

    cbfe_ctrl #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (xfer_start),
        .dir_in       (xfer_dir),
        .len_in       (xfer_len),
        .byte_moved   (byte_moved),
        .level        (fifo_level),
        .state        (state),
        .dir_q        (dir_q),
        .count        (byte_count),
        .end_flag     (end_flag),
        .busy         (busy),
        .last_byte    (last_byte),
        .rx_accept    (rx_accept),
        .tx_enable    (tx_enable),
        .host_push_ok (host_push_ok),
        .host_pop_ok  (host_pop_ok),
        .tx_flags     (tx_flags),
        .rx_flags     (rx_flags)
    );

    cbfe_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (xfer_start),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wdata),
        .rd_en   (fifo_rd),
        .rd_data (fifo_head),
        .level   (fifo_level),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    cbfe_rx_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .take      (rx_take),
        .last      (last_byte),
        .byte_in   (rx_byte),
        .word_push (pack_push),
        .word_out  (pack_word)
    );

    cbfe_tx_unpacker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (xfer_start),
        .enable     (tx_enable),
        .fifo_empty (fifo_empty),
        .head       (fifo_head),
        .byte_ready (tx_byte_ready),
        .byte_valid (tx_byte_valid),
        .byte_out   (tx_byte),
        .fifo_pop   (unpack_pop),
        .moved      (tx_moved)
    );

    logic unused_ok;
    assign unused_ok = &{1'b0, fifo_full, state, dir_q};

endmodule

// File: rtl/cbfe_checker.sv
module cbfe_checker #(
    parameter int LEN_W = 16,
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             busy,
    input logic [LEN_W-1:0] byte_count,
    input logic             data_end,
    input logic             block_end,
    input logic [4:0]       tx_flags,
    input logic [4:0]       rx_flags,
    input logic             rx_byte_valid,
    input logic             rx_byte_ready,
    input logic             tx_byte_valid,
    input logic             tx_byte_ready,
    input logic [LVL_W-1:0] fifo_level
);

    logic moved;
    assign moved = (rx_byte_valid && rx_byte_ready) || (tx_byte_valid && tx_byte_ready);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH)) else $error("level over depth"); // R1

    AST_ONE_DIR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !((tx_flags != 5'd0) && (rx_flags != 5'd0))) else $error("both flag groups"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_flags == 5'd0 && rx_flags == 5'd0)) else $error("flags while idle"); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> (byte_count == $past(byte_count) ||
                         byte_count == $past(byte_count) - LEN_W'(1))) else $error("count jump"); // R5

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_byte_ready && tx_byte_valid)) else $error("both lanes"); // R5

    AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (moved && byte_count == LEN_W'(1) && !xfer_start) |=> (data_end && block_end)) else $error("no end"); // R6

    AST_NO_MOVE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count == '0) |-> (!tx_byte_valid && !rx_byte_ready)) else $error("move at zero"); // R11

endmodule

bind card_byte_fifo_engine cbfe_checker #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_start    (xfer_start),
    .busy          (busy),
    .byte_count    (byte_count),
    .data_end      (data_end),
    .block_end     (block_end),
    .tx_flags      (tx_flags),
    .rx_flags      (rx_flags),
    .rx_byte_valid (rx_byte_valid),
    .rx_byte_ready (rx_byte_ready),
    .tx_byte_valid (tx_byte_valid),
    .tx_byte_ready (tx_byte_ready),
    .fifo_level    (fifo_level)
);

// File: tb/tb_card_byte_fifo_engine.sv
`timescale 1ns/1ps
module tb_card_byte_fifo_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_dir = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic [31:0] pop_data;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_ready;
    logic        tx_byte_valid;
    logic [7:0]  tx_byte;
    logic        tx_byte_ready = 1'b0;
    logic        busy;
    logic [15:0] byte_count;
    logic [14:0] word_count;
    logic        data_end;
    logic        block_end;
    logic [4:0]  tx_flags;
    logic [4:0]  rx_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    card_byte_fifo_engine dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_xfer(input logic dir, input logic [15:0] len);
        xfer_start = 1'b1; xfer_dir = dir; xfer_len = len;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        rx_byte_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        push_valid = 1'b1; push_data = w;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] w);
        chk(req, pop_data, w);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R7 busy after reset", busy, 0);
        chk("R8 tx flags after reset", tx_flags, 0);
        chk("R8 rx flags after reset", rx_flags, 0);
        chk("R5 count after reset", byte_count, 0);
        chk("R1 empty pop reads zero", pop_data, 0);
        pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;
        chk("R1 pop on empty ignored", pop_data, 0);
    endtask

    task automatic t_zero_len;
        start_xfer(1'b1, 16'd0);
        chk("R5 zero length stays idle", busy, 0);
        chk("R6 zero length data_end", data_end, 1);
        chk("R6 zero length block_end", block_end, 1);
    endtask

    task automatic t_rx_basic;
        start_xfer(1'b1, 16'd6);
        chk("R6 start clears data_end", data_end, 0);
        chk("R5 count loaded", byte_count, 6);
        chk("R10 word count for 6", word_count, 2);
        chk("R8 rx flags empty", rx_flags, 5'b00011);
        chk("R9 tx flags off in receive", tx_flags, 0);
        @(negedge clk);
        chk("R11 no byte without valid", byte_count, 6);
        for (int i = 0; i < 6; i++) feed(8'h11 + 8'(i));
        chk("R5 count reaches zero", byte_count, 0);
        chk("R6 data_end", data_end, 1);
        chk("R6 block_end", block_end, 1);
        chk("R8 rx flags two words", rx_flags, 5'b00101);
        chk("R10 word count zero", word_count, 0);
        pop_expect("R2 packed word lsb first", 32'h14131211);
        pop_expect("R3 partial word upper zero", 32'h00001615);
        chk("R7 still busy one cycle", busy, 1);
        chk("R8 rx empty flags", rx_flags, 5'b00011);
        @(negedge clk);
        chk("R7 idle after drain", busy, 0);
        chk("R7 flags dropped", rx_flags, 0);
    endtask

    task automatic t_tx_basic;
        start_xfer(1'b0, 16'd6);
        chk("R4 no byte with empty fifo", tx_byte_valid, 0);
        push(32'hA4A3A2A1);
        push(32'hDDCCB6B5);
        chk("R8 tx flags two words", tx_flags, 5'b10101);
        chk("R9 rx flags off in transmit", rx_flags, 0);
        @(negedge clk);
        chk("R11 tx waits for ready", byte_count, 6);
        tx_byte_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] e;
            e = (i < 4) ? (8'hA1 + 8'(i)) : (8'hB5 + 8'(i - 4));
            chk("R4 tx byte valid", tx_byte_valid, 1);
            chk("R4 tx byte order", tx_byte, e);
            @(negedge clk);
        end
        tx_byte_ready = 1'b0;
        chk("R5 tx count zero", byte_count, 0);
        chk("R6 tx data_end", data_end, 1);
        @(negedge clk);
        chk("R7 tx idle", busy, 0);
        chk("R7 tx flags dropped", tx_flags, 0);
    endtask

    task automatic t_tx_drain;
        start_xfer(1'b0, 16'd4);
        push(32'h44332211);
        push(32'h88776655);
        pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;
        chk("R12 host pop ignored in transmit move", tx_flags, 5'b10101);
        tx_byte_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R4 drain byte", tx_byte, 8'h11 + 8'(i * 17));
            @(negedge clk);
        end
        tx_byte_ready = 1'b0;
        push(32'hDEADBEEF);
        chk("R12 push ignored in drain", tx_flags, 5'b10101);
        chk("R7 busy with leftover word", busy, 1);
        pop_expect("R12 host pop in drain", 32'h88776655);
        @(negedge clk);
        chk("R7 idle after leftover popped", busy, 0);
    endtask

    task automatic t_rx_full;
        start_xfer(1'b1, 16'd80);
        push(32'hFFFFFFFF);
        chk("R12 host push ignored in receive", rx_flags, 5'b00011);
        for (int k = 0; k < 64; k++) begin
            feed(8'(k));
            if (k == 27) chk("R8 rx seven words", rx_flags, 5'b00101);
            if (k == 31) chk("R8 rx half at eight", rx_flags, 5'b10101);
        end
        chk("R8 rx full flags", rx_flags, 5'b11101);
        chk("R11 ready low when full", rx_byte_ready, 0);
        feed(8'hEE);
        chk("R1 byte refused when full", byte_count, 16);
        chk("R10 word count 16 bytes", word_count, 4);
        for (int w = 0; w < 16; w++)
            pop_expect("R1 fifo order", {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        for (int k = 64; k < 80; k++) feed(8'(k));
        for (int w = 16; w < 20; w++)
            pop_expect("R1 pointer wrap", {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        @(negedge clk);
        chk("R7 idle after full run", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_zero_len;
        t_rx_basic;
        t_tx_basic;
        t_tx_drain;
        t_rx_full;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule